// File: doc/BRIEF.md
# Parallel Spreading-Code Phase Search

This block finds where a known spreading code starts inside a stream of complex baseband samples taken at two samples per chip. The in-phase and quadrature rails each go through a sliding correlator with the same local code. One new correlation value per rail appears for every accepted sample. The value is tagged with a slot number that counts half-chip offsets across one code period of `2L` samples. Each slot adds up its rail correlations coherently over `M` symbols. It then forms a non-coherent energy (I squared plus Q squared) and adds that energy over `W` such blocks. A carrier phase offset on the input therefore does not change the result.

At the end of each window of `W·M` symbols, every slot is judged at once. The slot with the most energy gives the code phase. The signal is declared present only if that peak is larger than a programmable factor times the mean energy of the other slots. The decision is reported with a one-cycle done pulse. All accumulators then restart for the next window. The code pattern, `M`, `W` and the factor are run-time inputs. Their ceilings and the sample width are elaboration parameters.

Top module: `pn_phase_search`

## Requirements
- R1: After reset, `acq_done`, `acq_found` and `acq_phase` are all 0.
- R2: A code chip bit of 1 weighs a sample by +1, and a bit of 0 weighs it by −1. Within one code period of `2L` samples, bit `c` applies to samples `2c` and `2c+1`. The first `2L−1` samples after reset only fill the delay line. After that, slot `b` holds the correlation of the `2L` samples that start at sample `b + k·2L`. `acq_phase` is therefore the sample offset, modulo `2L`, at which a code period begins.
- R3: Scaling, negating or rotating the signal between the I and Q rails does not move the reported phase.
- R4: With `cfg_m` = M (1..MMAX), each slot's I and Q correlations are summed over M consecutive symbols before squaring. The squares of the two sums are then added.
- R5: `acq_done` is a single-cycle pulse. It comes two clock edges after the sample that completes `cfg_w·cfg_m` symbols (W from 1..WMAX), and again after every following such window. Each window starts from cleared accumulators.
- R6: The reported phase is the slot with the largest window energy. When slots are equal, the lowest slot number wins.
- R7: `acq_found` is 1 exactly when `16·(2L−1)·peak > λ·(total − peak)`. Here `cfg_lambda` = λ is unsigned Q4.4 (value λ/16), and total is the sum of all slot energies.
- R8: `acq_phase` and `acq_found` change only in the cycle in which `acq_done` is high.
- R9: Full-scale inputs at the largest M and W give exact energies, with no wrap.
- R10: Cycles with `smp_vld` low have no effect on any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Sample strobe |
| smp_i | input | IW | In-phase sample, signed |
| smp_q | input | IW | Quadrature sample, signed |
| code_chips | input | L | Local code, bit c = chip c |
| cfg_m | input | clog2(MMAX+1) | Coherent symbols per block |
| cfg_w | input | clog2(WMAX+1) | Blocks per window |
| cfg_lambda | input | 8 | Detection factor, unsigned Q4.4 |
| acq_done | output | 1 | Window decision strobe |
| acq_phase | output | clog2(2L) | Code start offset in half chips |
| acq_found | output | 1 | Signal present flag |

## Verification
The assertions assume that `cfg_m` and `cfg_w` are nonzero and within their ceilings whenever a correlation is taken. They also assume that configuration and code stay constant between resets, because a mid-window change would mix two block lengths. The stimulus resets the block before every scenario and sets all configuration while reset is held. Each window ends with a few idle cycles, so the done pulse can be matched against the exact number of samples accepted. Valid-strobe gaps are placed only within a window, which keeps every case inside what the checks assume.

// File: rtl/pnacq_pkg.sv
package pnacq_pkg;

   // signed width of one single-symbol correlation over nb samples
   function automatic int corr_w(int iw, int nb);
      return iw + $clog2(nb) + 1;
   endfunction

   // signed width of a coherent sum over up to mmax symbols
   function automatic int coh_w(int iw, int nb, int mmax);
      return corr_w(iw, nb) + $clog2(mmax + 1);
   endfunction

   // unsigned width of a slot energy summed over up to wmax blocks
   function automatic int energy_w(int iw, int nb, int mmax, int wmax);
      return 2 * coh_w(iw, nb, mmax) + $clog2(wmax + 1);
   endfunction

endpackage

// File: rtl/pnacq_corr.sv
module pnacq_corr #(
   parameter int IW = 12,
   parameter int L  = 16,
   localparam int NB = 2 * L,
   localparam int CW = pnacq_pkg::corr_w(IW, NB)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 shift_en,
   input  logic signed [IW-1:0] din,
   input  logic [L-1:0]         code,
   output logic signed [CW-1:0] dout
);

   logic signed [IW-1:0] tap_q [NB];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < NB; k++) tap_q[k] <= '0;
      end else if (shift_en) begin
         tap_q[0] <= din;
         for (int k = 1; k < NB; k++) tap_q[k] <= tap_q[k-1];
      end
   end

   // tap_q[j] is the sample j steps old; window position is NB-1-j
   always_comb begin
      dout = '0;
      for (int j = 0; j < NB; j++) begin
         if (code[(NB - 1 - j) / 2])
            dout = dout + CW'(tap_q[j]);
         else
            dout = dout - CW'(tap_q[j]);
      end
   end

endmodule

// File: rtl/pnacq_bins.sv
module pnacq_bins #(
   parameter int NB   = 32,
   parameter int IW   = 12,
   parameter int MMAX = 4,
   parameter int WMAX = 16,
   localparam int LG = $clog2(NB),
   localparam int MW = $clog2(MMAX + 1),
   localparam int WW = $clog2(WMAX + 1),
   localparam int CW = pnacq_pkg::corr_w(IW, NB),
   localparam int HW = pnacq_pkg::coh_w(IW, NB, MMAX),
   localparam int EW = pnacq_pkg::energy_w(IW, NB, MMAX, WMAX)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cvld,
   input  logic signed [CW-1:0] ci,
   input  logic signed [CW-1:0] cq,
   input  logic [MW-1:0]        cfg_m,
   input  logic [WW-1:0]        cfg_w,
   output logic [EW-1:0]        en_o [NB],
   output logic                 win_end
);

   logic [LG:0]          fill_q;
   logic [LG-1:0]        bin_q;
   logic [MW-1:0]        sym_q;
   logic [WW-1:0]        blk_q;
   logic signed [HW-1:0] coh_i_q [NB];
   logic signed [HW-1:0] coh_q_q [NB];
   logic [EW-1:0]        en_q [NB];

   logic                 rdy, take;
   logic                 first_sym, last_sym, first_blk, last_blk, last_bin;
   logic signed [HW-1:0] sum_i, sum_q;
   logic signed [2*HW-1:0] sq_i, sq_q;
   logic [EW-1:0]        en_next;

   assign rdy  = (fill_q == (LG+1)'(NB - 1));
   assign take = cvld && rdy;

   always_comb begin
      first_sym = (sym_q == '0);
      last_sym  = (sym_q == cfg_m - MW'(1));
      first_blk = (blk_q == '0);
      last_blk  = (blk_q == cfg_w - WW'(1));
      last_bin  = (bin_q == LG'(NB - 1));
      sum_i     = (first_sym ? HW'(0) : coh_i_q[bin_q]) + HW'(ci);
      sum_q     = (first_sym ? HW'(0) : coh_q_q[bin_q]) + HW'(cq);
      sq_i      = sum_i * sum_i;
      sq_q      = sum_q * sum_q;
      en_next   = (first_blk ? EW'(0) : en_q[bin_q])
                + EW'($unsigned(sq_i)) + EW'($unsigned(sq_q));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fill_q  <= '0;
         bin_q   <= '0;
         sym_q   <= '0;
         blk_q   <= '0;
         win_end <= 1'b0;
         for (int k = 0; k < NB; k++) begin
            coh_i_q[k] <= '0;
            coh_q_q[k] <= '0;
            en_q[k]    <= '0;
         end
      end else begin
         win_end <= 1'b0;
         if (cvld && !rdy) fill_q <= fill_q + 1'b1;
         if (take) begin
            coh_i_q[bin_q] <= sum_i;
            coh_q_q[bin_q] <= sum_q;
            if (last_sym) en_q[bin_q] <= en_next;
            bin_q <= last_bin ? '0 : bin_q + 1'b1;
            if (last_bin) begin
               if (last_sym) begin
                  sym_q <= '0;
                  if (last_blk) begin
                     blk_q   <= '0;
                     win_end <= 1'b1;
                  end else begin
                     blk_q <= blk_q + 1'b1;
                  end
               end else begin
                  sym_q <= sym_q + 1'b1;
               end
            end
         end
      end
   end

   assign en_o = en_q;

   p_cfg_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cvld |-> (cfg_m >= MW'(1) && cfg_m <= MW'(MMAX) &&
                cfg_w >= WW'(1) && cfg_w <= WW'(WMAX)));

   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (take && last_sym && !first_blk) |-> (en_next >= en_q[bin_q]));

   p_gap_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !cvld |=> ($stable(bin_q) && $stable(sym_q) && $stable(blk_q)));

endmodule

// File: rtl/pnacq_pick.sv
module pnacq_pick #(
   parameter int NB = 32,
   parameter int EW = 40,
   localparam int LG   = $clog2(NB),
   localparam int SW   = EW + LG,
   localparam int CMPW = EW + LG + 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          eval,
   input  logic [EW-1:0] en [NB],
   input  logic [7:0]    lambda,
   output logic          done,
   output logic [LG-1:0] phase,
   output logic          found
);

   localparam logic [CMPW-1:0] KSCALE = CMPW'(16 * (NB - 1));

   // heap-ordered comparison tree, node 1 is the root
   logic [EW-1:0] node_v [1:2*NB-1];
   logic [LG-1:0] node_i [1:2*NB-1];

   for (genvar k = 0; k < NB; k++) begin : g_leaf
      assign node_v[NB + k] = en[k];
      assign node_i[NB + k] = LG'(k);
   end

   for (genvar n = 1; n < NB; n++) begin : g_node
      // the right child wins only when strictly larger: ties keep the lower slot
      assign node_v[n] = (node_v[2*n+1] > node_v[2*n]) ? node_v[2*n+1] : node_v[2*n];
      assign node_i[n] = (node_v[2*n+1] > node_v[2*n]) ? node_i[2*n+1] : node_i[2*n];
   end

   logic [SW-1:0]   total;
   logic [CMPW-1:0] lhs, rhs;

   always_comb begin
      total = '0;
      for (int k = 0; k < NB; k++) total = total + SW'(en[k]);
      lhs = CMPW'(node_v[1]) * KSCALE;
      rhs = CMPW'(lambda) * CMPW'(total - SW'(node_v[1]));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done  <= 1'b0;
         phase <= '0;
         found <= 1'b0;
      end else begin
         done <= eval;
         if (eval) begin
            phase <= node_i[1];
            found <= (lhs > rhs);
         end
      end
   end

   p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(phase) && $stable(found)));

endmodule

// File: rtl/pn_phase_search.sv
module pn_phase_search #(
   parameter int IW   = 12,
   parameter int L    = 16,
   parameter int MMAX = 4,
   parameter int WMAX = 16,
   localparam int NB = 2 * L,
   localparam int LG = $clog2(NB),
   localparam int MW = $clog2(MMAX + 1),
   localparam int WW = $clog2(WMAX + 1),
   localparam int CW = pnacq_pkg::corr_w(IW, NB),
   localparam int EW = pnacq_pkg::energy_w(IW, NB, MMAX, WMAX)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 smp_vld,
   input  logic signed [IW-1:0] smp_i,
   input  logic signed [IW-1:0] smp_q,
   input  logic [L-1:0]         code_chips,
   input  logic [MW-1:0]        cfg_m,
   input  logic [WW-1:0]        cfg_w,
   input  logic [7:0]           cfg_lambda,
   output logic                 acq_done,
   output logic [LG-1:0]        acq_phase,
   output logic                 acq_found
);

   if (L < 2 || (L & (L - 1)) != 0) begin : g_bad_len
      $error("code length must be a power of two of at least 2");
   end
   if (IW < 2 || MMAX < 1 || WMAX < 1) begin : g_bad_dim
      $error("sample width and accumulation ceilings out of range");
   end
   if (L * MMAX * WMAX > 512000) begin : g_bad_latency
      $error("window latency ceiling exceeded");
   end

   logic signed [IW-1:0] rail_in  [2];
   logic signed [CW-1:0] rail_out [2];
   logic                 cvld_q;
   logic [EW-1:0]        energy [NB];
   logic                 win_end;

   assign rail_in[0] = smp_i;
   assign rail_in[1] = smp_q;

   for (genvar r = 0; r < 2; r++) begin : g_rail
      pnacq_corr #(.IW(IW), .L(L)) u_corr (
         .clk      (clk),
         .rst_n    (rst_n),
         .shift_en (smp_vld),
         .din      (rail_in[r]),
         .code     (code_chips),
         .dout     (rail_out[r])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cvld_q <= 1'b0;
      else        cvld_q <= smp_vld;
   end

   pnacq_bins #(.NB(NB), .IW(IW), .MMAX(MMAX), .WMAX(WMAX)) u_bins (
      .clk     (clk),
      .rst_n   (rst_n),
      .cvld    (cvld_q),
      .ci      (rail_out[0]),
      .cq      (rail_out[1]),
      .cfg_m   (cfg_m),
      .cfg_w   (cfg_w),
      .en_o    (energy),
      .win_end (win_end)
   );

   pnacq_pick #(.NB(NB), .EW(EW)) u_pick (
      .clk    (clk),
      .rst_n  (rst_n),
      .eval   (win_end),
      .en     (energy),
      .lambda (cfg_lambda),
      .done   (acq_done),
      .phase  (acq_phase),
      .found  (acq_found)
   );

   p_end_to_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      win_end |=> acq_done);

endmodule

// File: tb/pn_phase_search_tb.sv
module pn_phase_search_tb;

   localparam int IW = 12, L = 16, MMAX = 4, WMAX = 16;
   localparam int NB = 2 * L;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic smp_vld = 1'b0;
   logic signed [IW-1:0] smp_i = '0, smp_q = '0;
   logic [L-1:0] code_chips = 16'hB38E;
   logic [2:0] cfg_m = 3'd1;
   logic [4:0] cfg_w = 5'd4;
   logic [7:0] cfg_lambda = 8'd48;
   logic acq_done, acq_found;
   logic [4:0] acq_phase;

   always #10 clk = ~clk;

   pn_phase_search #(.IW(IW), .L(L), .MMAX(MMAX), .WMAX(WMAX)) u_dut (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_i(smp_i), .smp_q(smp_q),
      .code_chips(code_chips), .cfg_m(cfg_m), .cfg_w(cfg_w), .cfg_lambda(cfg_lambda),
      .acq_done(acq_done), .acq_phase(acq_phase), .acq_found(acq_found)
   );

   typedef struct {
      int    phase;
      int    found;
      int    cnt;
      string tag;
   } exp_t;

   exp_t   sb_q[$];
   int     checks = 0, errors = 0;
   int     xi [0:4095];
   int     xq [0:4095];
   int     acc_cnt = 0;
   int     lfsr = 32'h1D3A;
   logic   hold_bad = 1'b0;
   logic [4:0] prev_phase = '0;
   logic   prev_found = 1'b0;
   logic   ended = 1'b0;

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   function automatic int noise_next(int amp);
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 0);
      if (amp == 0) return 0;
      return (lfsr % (2 * amp + 1)) - amp;
   endfunction

   function automatic int chip_sgn(int pos);
      return code_chips[pos / 2] ? 1 : -1;
   endfunction

   // builds nsamp samples whose code period begins at sample offset s
   task automatic build(input int s, input int ai, input int aq, input int namp, input int nsamp);
      for (int n = 0; n < nsamp; n++) begin
         int p;
         p = ((n - s) % NB + NB) % NB;
         xi[n] = ai * chip_sgn(p) + noise_next(namp);
         xq[n] = aq * chip_sgn(p) + noise_next(namp);
      end
   endtask

   function automatic longint corr(int n, bit q);
      longint a = 0;
      for (int t = 0; t < NB; t++)
         a += longint'(q ? xq[n - NB + 1 + t] : xi[n - NB + 1 + t]) * chip_sgn(t);
      return a;
   endfunction

   // reference decision for every window, pushed to the scoreboard
   task automatic expect_windows(input int nwin, input int m, input int w, input int lam, input string tag);
      for (int win = 0; win < nwin; win++) begin
         longint e [NB];
         longint tot = 0;
         int best = 0;
         exp_t it;
         for (int b = 0; b < NB; b++) begin
            e[b] = 0;
            for (int k = 0; k < w; k++) begin
               longint si = 0, sq = 0;
               for (int s = 0; s < m; s++) begin
                  int n;
                  n = NB - 1 + ((win * w + k) * m + s) * NB + b;
                  si += corr(n, 1'b0);
                  sq += corr(n, 1'b1);
               end
               e[b] += si * si + sq * sq;
            end
            tot += e[b];
            if (e[b] > e[best]) best = b;
         end
         it.phase = best;
         it.found = (longint'(16 * (NB - 1)) * e[best] > longint'(lam) * (tot - e[best])) ? 1 : 0;
         it.cnt   = NB - 1 + (win + 1) * w * m * NB;
         it.tag   = tag;
         sb_q.push_back(it);
      end
   endtask

   task automatic do_reset(input int m, input int w, input int lam);
      @(negedge clk);
      rst_n = 1'b0;
      smp_vld = 1'b0;
      cfg_m = 3'(m);
      cfg_w = 5'(w);
      cfg_lambda = 8'(lam);
      repeat (3) @(negedge clk);
      acc_cnt = 0;
      rst_n = 1'b1;
   endtask

   // drives nsamp samples, idling three cycles after each window boundary
   task automatic drive(input int nsamp, input int m, input int w, input bit gaps);
      int per;
      per = w * m * NB;
      for (int n = 0; n < nsamp; n++) begin
         if (gaps && (n % 7 == 3)) begin
            smp_vld = 1'b0;
            smp_i = 12'sh5A5;
            smp_q = -12'sd700;
            @(negedge clk);
         end
         smp_vld = 1'b1;
         smp_i = IW'(xi[n]);
         smp_q = IW'(xq[n]);
         @(negedge clk);
         acc_cnt++;
         smp_vld = 1'b0;
         if (n + 1 > NB - 1 && ((n + 1 - (NB - 1)) % per) == 0)
            repeat (3) @(negedge clk);
      end
      smp_vld = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic scenario(input int s, input int ai, input int aq, input int namp,
                           input int m, input int w, input int lam, input int nwin,
                           input bit gaps, input string tag);
      int nsamp;
      nsamp = NB - 1 + nwin * w * m * NB;
      build(s, ai, aq, namp, nsamp);
      do_reset(m, w, lam);
      expect_windows(nwin, m, w, lam, tag);
      drive(nsamp, m, w, gaps);
   endtask

   // monitor: pops the scoreboard on each done pulse
   always @(negedge clk) begin
      if (!rst_n) begin
         prev_phase <= '0;
         prev_found <= 1'b0;
         hold_bad   <= 1'b0;
      end else begin
         if (!acq_done && (acq_phase != prev_phase || acq_found != prev_found))
            hold_bad <= 1'b1;
         if (acq_done) begin
            check(!hold_bad, "R8 outputs held between pulses", hold_bad, 0);
            hold_bad <= 1'b0;
            if (sb_q.size() == 0) begin
               check(1'b0, "R5 unexpected done", 1, 0);
            end else begin
               exp_t it;
               it = sb_q.pop_front();
               check(int'(acq_phase) == it.phase, {it.tag, " phase"}, acq_phase, it.phase);
               check(int'(acq_found) == it.found, {it.tag, " R7 found"}, acq_found, it.found);
               check(acc_cnt == it.cnt, "R5 samples per window", acc_cnt, it.cnt);
            end
         end
         prev_phase <= acq_phase;
         prev_found <= acq_found;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      do_reset(1, 4, 48);
      @(negedge clk);
      check(acq_done == 1'b0, "R1 done after reset", acq_done, 0);
      check(acq_found == 1'b0, "R1 found after reset", acq_found, 0);
      check(acq_phase == '0, "R1 phase after reset", acq_phase, 0);

      // R2: clear code at offset 5, two windows
      scenario(5, 300, 0, 20, 1, 4, 48, 2, 1'b0, "R2 R6 offset5");
      // R3 and R10: rotated carrier with strobe gaps
      scenario(22, -120, 160, 30, 1, 4, 48, 2, 1'b1, "R3 R10 rotated");
      // R4: two coherent symbols per block
      scenario(13, 40, 25, 60, 2, 2, 40, 2, 1'b0, "R4 coherent");
      // R7: noise only, high factor
      scenario(0, 0, 0, 200, 1, 4, 64, 1, 1'b0, "R7 noise");
      // R7: low factor on a weak signal
      scenario(31, 15, -10, 100, 1, 2, 8, 1, 1'b0, "R7 weak");
      // R6: all-zero input gives equal slots
      scenario(9, 0, 0, 0, 1, 1, 16, 1, 1'b0, "R6 tie");
      // R9: full scale at the ceilings
      scenario(17, 2047, -2047, 0, MMAX, WMAX, 255, 1, 1'b0, "R9 fullscale");

      repeat (5) @(negedge clk);
      check(sb_q.size() == 0, "R5 all windows reported", sb_q.size(), 0);
      finish_run();
   end

endmodule